// File: doc/BRIEF.md
# Single-Line NMI Request Conditioner

This block watches one asynchronous non-maskable interrupt input and presents a level-high request to a parent interrupt controller. The input first passes through a synchronizer. It is then judged by one of four trigger rules: low level, high level, falling edge or rising edge. A qualifying event sets a pending flag, and an enable bit gates that flag onto the request line.

Software uses a small single-cycle register bus with three words. The control word holds the trigger code. The pending word reports the flag, and software clears the flag by writing a one to it. The enable word masks or unmasks the request.

The offset of the enable word is a build parameter. This lets the same RTL produce both register layouts: enable at 0x08, or enable at 0x34.

Top module: `nmi_line_ctrl`

## Requirements
- R1: After reset, with the input held high, the control word reads 0, the pending and enable words read 0, and `irq_out` is low.
- R2: The control word is at offset 0x00 and stores the full 32-bit value written to it. Bits [1:0] select the trigger: 0 is low level, 1 is falling edge, 2 is high level, 3 is rising edge. Changing the trigger field through a read-modify-write leaves the upper bits as they were.
- R3: The input passes through a two-flop synchronizer. In an edge mode, pending is set on the selected transition of the synchronized input and is visible on the third rising clock edge after the input changes. It then stays set until acknowledged.
- R4: Pending is reported in bit 0 of offset 0x04, and the other bits read 0. In an edge mode, writing 1 to bit 0 clears pending. Writing 0 leaves it unchanged.
- R5: If a selected edge is detected in the same cycle as an acknowledge write, pending stays set.
- R6: In a level mode, pending equals the active level of the synchronized input, one cycle later. An acknowledge cannot clear it while the level is still active.
- R7: The enable bit is bit 0 of offset EN_OFFSET (0x08 by default, 0x34 in the other layout), and the other bits read 0. `irq_out` is high exactly when both pending and enable are set. Clearing enable does not clear pending.
- R8: In the cycle where a control write changes the trigger field, no edge is detected. A trigger change therefore never sets pending by itself.
- R9: A read of any other offset returns 0. A write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Raw asynchronous interrupt input |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as a read |
| irq_out | output | 1 | Level-high request to the parent controller |

## Verification
Two things can land on the pending flag in the same cycle: a newly detected edge and a software acknowledge. The bench provokes this by raising the input and then issuing the acknowledge write exactly two cycles later, which is when the synchronized edge is evaluated. The expected outcome is that pending stays set. A second kind of collision, a trigger change that coincides with an input transition, arises in the random phase. In every case a cycle-level reference model in the bench decides whether pending should be set or clear.

// File: rtl/nmi_line_pkg.sv
package nmi_line_pkg;

    typedef enum logic [1:0] {
        TRG_LVL_LO = 2'd0,
        TRG_FALL   = 2'd1,
        TRG_LVL_HI = 2'd2,
        TRG_RISE   = 2'd3
    } trig_e;

    localparam int OFF_CTRL = 'h00;
    localparam int OFF_PEND = 'h04;

    typedef struct packed {
        logic prev;
        logic pending;
    } evt_state_t;

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_event.sv
module nmi_event
    import nmi_line_pkg::*;
#(
    parameter logic RST_VAL = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sync_lvl,
    input  trig_e trig,
    input  logic  mode_chg,
    input  logic  ack,
    output logic  pending,
    output logic  edge_hit,
    output logic  level_act
);
    evt_state_t st_d, st_q;
    logic is_level;
    logic lvl_true;
    logic rise;
    logic fall;

    always_comb begin
        st_d     = st_q;
        is_level = (trig == TRG_LVL_LO) || (trig == TRG_LVL_HI);
        lvl_true = (trig == TRG_LVL_LO) ? ~sync_lvl : sync_lvl;
        rise     = sync_lvl & ~st_q.prev;
        fall     = ~sync_lvl & st_q.prev;
        case (trig)
            TRG_RISE: edge_hit = rise;
            TRG_FALL: edge_hit = fall;
            default:  edge_hit = 1'b0;
        endcase
        if (mode_chg) edge_hit = 1'b0;
        level_act = is_level & lvl_true;
        if (is_level) st_d.pending = lvl_true;
        else          st_d.pending = (st_q.pending & ~ack) | edge_hit;
        st_d.prev = sync_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: RST_VAL, pending: 1'b0};
        else        st_q <= st_d;
    end

    assign pending = st_q.pending;
endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
    import nmi_line_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int EN_OFFSET = 'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pending,
    output logic [DATA_W-1:0] ctrl_word,
    output trig_e             trig,
    output logic              enable,
    output logic              mode_chg,
    output logic              ack
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_OFFSET);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              en;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        ack       = 1'b0;
        mode_chg  = 1'b0;
        bus_rdata = '0;
        if (bus_sel && bus_we) begin
            if (bus_addr == A_CTRL) begin
                st_d.ctrl = bus_wdata;
                mode_chg  = (bus_wdata[1:0] != st_q.ctrl[1:0]);
            end else if (bus_addr == A_PEND) begin
                ack = bus_wdata[0];
            end else if (bus_addr == A_EN) begin
                st_d.en = bus_wdata[0];
            end
        end
        if (bus_sel && !bus_we) begin
            if (bus_addr == A_CTRL)      bus_rdata = st_q.ctrl;
            else if (bus_addr == A_PEND) bus_rdata = {{(DATA_W-1){1'b0}}, pending};
            else if (bus_addr == A_EN)   bus_rdata = {{(DATA_W-1){1'b0}}, st_q.en};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_word = st_q.ctrl;
    assign trig      = trig_e'(st_q.ctrl[1:0]);
    assign enable    = st_q.en;
endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
    import nmi_line_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int EN_OFFSET   = 'h08,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_in,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam logic IDLE_LVL = 1'b1;

    logic              sync_lvl;
    logic              pend_q;
    logic              edge_hit;
    logic              level_act;
    logic [DATA_W-1:0] ctrl_word;
    trig_e             trig;
    logic              en_q;
    logic              mode_chg;
    logic              ack;

    nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (nmi_in),
        .dout (sync_lvl)
    );

    nmi_event #(.RST_VAL(IDLE_LVL)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_lvl (sync_lvl),
        .trig     (trig),
        .mode_chg (mode_chg),
        .ack      (ack),
        .pending  (pend_q),
        .edge_hit (edge_hit),
        .level_act(level_act)
    );

    nmi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_OFFSET(EN_OFFSET)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pending  (pend_q),
        .ctrl_word(ctrl_word),
        .trig     (trig),
        .enable   (en_q),
        .mode_chg (mode_chg),
        .ack      (ack)
    );

    assign irq_out = pend_q & en_q;
endmodule

// File: rtl/nmi_line_chk.sv
module nmi_line_chk #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int EN_OFFSET = 'h08
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_out,
    input logic              pend_q,
    input logic              en_q,
    input logic [DATA_W-1:0] ctrl_word,
    input logic              edge_hit,
    input logic              level_act
);
    localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(EN_OFFSET);

    logic lvl_mode;
    logic unmapped;
    logic zero_ack;

    assign lvl_mode = (ctrl_word[0] == 1'b0);
    assign unmapped = (bus_addr != '0) && (bus_addr != ADDR_W'(4)) && (bus_addr != A_EN);
    assign zero_ack = bus_sel && bus_we && (bus_addr == ADDR_W'(4)) && !bus_wdata[0];

    AST_CTRL_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == '0) |=> (ctrl_word == $past(bus_wdata))); // R2

    AST_ZERO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_ack && pend_q && !lvl_mode && !(bus_sel && bus_we && bus_addr == '0)) |=> pend_q); // R4

    AST_ACK_RACE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> pend_q); // R5

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_mode |=> (pend_q == $past(level_act))); // R6

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !irq_out); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && unmapped) |-> (bus_rdata == '0)); // R9
endmodule

bind nmi_line_ctrl nmi_line_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_OFFSET(EN_OFFSET)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_out  (irq_out),
    .pend_q   (pend_q),
    .en_q     (en_q),
    .ctrl_word(ctrl_word),
    .edge_hit (edge_hit),
    .level_act(level_act)
);

// File: tb/sim_nmi_line_ctrl.sv
module sim_nmi_line_ctrl;
    localparam int EN_OFF = 'h08;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_in = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    logic nin_v = 1'b1;

    // reference model state
    logic        m_s1, m_s2, m_prev, m_pend, m_en;
    logic [31:0] m_ctrl;

    always #2.5 clk = ~clk;

    nmi_line_ctrl #(.EN_OFFSET(EN_OFF)) u0 (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        if (a == 8'h00)              return m_ctrl;
        else if (a == 8'h04)         return {31'b0, m_pend};
        else if (a == 8'(EN_OFF))    return {31'b0, m_en};
        else                         return 32'h0;
    endfunction

    task automatic model_reset();
        m_s1 = 1'b1; m_s2 = 1'b1; m_prev = 1'b1;
        m_pend = 1'b0; m_en = 1'b0; m_ctrl = 32'h0;
    endtask

    task automatic model_update(input logic sel, input logic we, input logic [7:0] a,
                                input logic [31:0] wd, input logic nin);
        logic s, edge_v, chg, ackv, lvl;
        s    = m_s2;
        chg  = sel && we && (a == 8'h00) && (wd[1:0] != m_ctrl[1:0]);
        ackv = sel && we && (a == 8'h04) && wd[0];
        case (m_ctrl[1:0])
            2'd3:    edge_v = s && !m_prev;
            2'd1:    edge_v = !s && m_prev;
            default: edge_v = 1'b0;
        endcase
        if (chg) edge_v = 1'b0;
        lvl = (m_ctrl[1:0] == 2'd0) ? !s : s;
        if (m_ctrl[0] == 1'b0) m_pend = lvl;
        else                   m_pend = (m_pend && !ackv) || edge_v;
        m_prev = s;
        m_s2 = m_s1;
        m_s1 = nin;
        if (sel && we && a == 8'h00)           m_ctrl = wd;
        if (sel && we && a == 8'(EN_OFF))      m_en = wd[0];
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input logic sel, input logic we,
                        input logic [7:0] a, input logic [31:0] wd);
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd; nmi_in = nin_v;
        #1;
        if (sel && !we) check(tag, "rdata", bus_rdata, model_rd(a));
        check(tag, "irq", {31'b0, irq_out}, {31'b0, m_pend && m_en});
        @(posedge clk);
        model_update(sel, we, a, wd, nin_v);
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, 8'h00, 32'h0);
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        step(tag, 1'b1, 1'b0, a, 32'h0);
    endtask

    task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] d);
        step(tag, 1'b1, 1'b1, a, d);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] t;
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd("R1", 8'h00); rd("R1", 8'h04); rd("R1", 8'(EN_OFF));
        idle("R1", 3);

        // R2: full word stored, RMW keeps upper bits
        wr("R2", 8'h00, 32'hABCD_0003);
        rd("R2", 8'h00);
        t = 32'hABCD_0003;
        t[1:0] = 2'd1;
        wr("R2", 8'h00, t);
        rd("R2", 8'h00);
        wr("R2", 8'h00, 32'h1234_5673);

        // R7: unmask
        wr("R7", 8'(EN_OFF), 32'hFFFF_FFFF);
        rd("R7", 8'(EN_OFF));

        // R3: rising edge latches and holds
        nin_v = 1'b0; idle("R3", 4);
        nin_v = 1'b1; idle("R3", 1); rd("R3", 8'h04); rd("R3", 8'h04); rd("R3", 8'h04);
        idle("R3", 2);
        // R4: zero write holds, one write clears
        wr("R4", 8'h04, 32'hFFFF_FFFE); rd("R4", 8'h04);
        wr("R4", 8'h04, 32'h1); rd("R4", 8'h04);

        // R7: mask keeps pending, unmask raises again
        nin_v = 1'b0; idle("R7", 3); nin_v = 1'b1; idle("R7", 4);
        wr("R7", 8'(EN_OFF), 32'h0); idle("R7", 2); rd("R7", 8'h04);
        wr("R7", 8'(EN_OFF), 32'h1); idle("R7", 2);
        wr("R4", 8'h04, 32'h1);

        // R5: edge and acknowledge in the same cycle
        nin_v = 1'b0; idle("R5", 4);
        nin_v = 1'b1; idle("R5", 2);
        wr("R5", 8'h04, 32'h1); rd("R5", 8'h04); idle("R5", 2);
        wr("R5", 8'h04, 32'h1); rd("R5", 8'h04);

        // R3: falling edge mode
        wr("R3", 8'h00, 32'h0000_0001); idle("R3", 2);
        nin_v = 1'b0; idle("R3", 4); rd("R3", 8'h04);
        wr("R3", 8'h04, 32'h1);

        // R6: high level follows input, ack cannot clear
        wr("R6", 8'h00, 32'h0000_0002); idle("R6", 2);
        nin_v = 1'b1; idle("R6", 4); rd("R6", 8'h04);
        wr("R6", 8'h04, 32'h1); rd("R6", 8'h04);
        nin_v = 1'b0; idle("R6", 4); rd("R6", 8'h04);
        // R6: low level
        wr("R6", 8'h00, 32'h0); idle("R6", 2); rd("R6", 8'h04);
        nin_v = 1'b1; idle("R6", 4); rd("R6", 8'h04);

        // R8: trigger changes on a steady input set nothing
        wr("R8", 8'h00, 32'h3); idle("R8", 2); rd("R8", 8'h04);
        wr("R8", 8'h00, 32'h1); idle("R8", 2); rd("R8", 8'h04);
        wr("R8", 8'h00, 32'h3); idle("R8", 2); rd("R8", 8'h04);

        // R9: unmapped offsets
        wr("R9", 8'h10, 32'hFFFF_FFFF); wr("R9", 8'h0C, 32'hFFFF_FFFF);
        rd("R9", 8'h10); rd("R9", 8'h34); rd("R9", 8'h00); rd("R9", 8'(EN_OFF));

        // random phase (all requirements, model-checked each cycle)
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [7:0] a;
            r = $urandom % 16;
            if (($urandom % 4) == 0) nin_v = ~nin_v;
            case ($urandom % 4)
                0: a = 8'h00;
                1: a = 8'h04;
                2: a = 8'(EN_OFF);
                default: a = 8'h40 | 8'($urandom % 64);
            endcase
            if (r < 5)       idle("R3", 1);
            else if (r < 10) rd("R8", a);
            else if (a == 8'h00 && r < 14) wr("R2", a, $urandom | 32'h0);
            else if (a == 8'h00) idle("R2", 1);
            else             wr("R5", a, $urandom);
        end

        summary();
        $finish;
    end
endmodule